// File: doc/BRIEF.md
# Clock-Domain Idle Commit Controller

This block sequences the power-down of ten clock domains: the CPU, the master port, the instruction cache, the peripherals, the clock generator, the external memory interface, the I/O port, the DMA port, the instruction port and an extended clock qualifier. Software writes a staged idle configuration through a small register port. That value does nothing until the one-cycle idle strobe arrives. The strobe then copies the configuration into a read-only status register. Each domain's clock-enable output is the registered inverse of its status bit.

A request to stop the clock generator is checked before it is committed. If the request is illegal, the block emits a one-cycle bus-error pulse and leaves the status register as it was. While the CPU domain is idle, an interrupt from an enabled source wakes the device. The wake clears a fixed subset of the status bits and pulses a resume signal to the CPU. If the clock generator had been stopped, the oscillator must first settle, so the block counts a programmable number of reference-clock cycles (41,032 by default) before the clear and the resume take place.

Top module: `idle_commit_ctrl`

## Requirements
- R1: After reset the configuration, status and wake-enable registers read zero, every `dom_clk_en` bit is 1, and `bus_err` and `cpu_resume` are 0.
- R2: Register select 0 is the staged configuration. Bits 9..0 are writable in domain order: CPU 0, master port 1, instruction cache 2, peripherals 3, clock generator 4, external memory 5, I/O port 6, DMA port 7, instruction port 8, extended clock 9. Bits 15..10 always read 0.
- R3: Writing the configuration changes neither the status register nor any enable. A write to register select 1 (status) is ignored.
- R4: When `idle_strobe` is high and the request is legal, the status register (select 1, same bit layout) takes the configuration value at that clock edge.
- R5: Each `dom_clk_en[i]` equals the inverse of status bit i as it stood one cycle earlier.
- R6: A strobe with bit 4 set and any of bits 0, 1, 2, 5, 6, 7, 8 or 9 clear produces a one-cycle `bus_err` pulse and leaves status unchanged. Bit 3 is not required for a legal stop.
- R7: Register select 2 is the wake enable: bits 3..0 enable `irq_in[3:0]`, bit 4 enables `nmi_in`, and bits 15..5 read 0. A wake event needs an enabled NMI, or an interrupt whose wake-enable bit and `irq_en` bit are both 1. An event counts only while status bit 0 is 1.
- R8: A wake event while status bit 4 is 0 clears status bits 0, 4, 5, 6 and 8 at that edge and raises `cpu_resume` for one cycle. All other status bits and the configuration keep their values.
- R9: A wake event while status bit 4 is 1 starts a countdown. The clear and the `cpu_resume` pulse of R8 occur STAB_CYCLES cycles after the edge that accepted the wake.
- R10: During the countdown, further interrupts do not restart it and `idle_strobe` is ignored.
- R11: When a wake event and `idle_strobe` fall in the same cycle, the wake takes effect and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, free-running |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 configuration, 1 status, 2 wake enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| idle_strobe | input | 1 | One-cycle commit request from the idle instruction |
| irq_in | input | 4 | External interrupt lines |
| irq_en | input | 4 | Interrupt enable mask from the interrupt controller |
| nmi_in | input | 1 | Non-maskable interrupt |
| dom_clk_en | output | 10 | Registered clock enable per domain, 1 = clock running |
| bus_err | output | 1 | One-cycle pulse on an illegal clock-stop commit |
| cpu_resume | output | 1 | One-cycle pulse when the CPU may resume |

## Verification
The embedded assertions check several rules on every cycle:
- the enables trail the inverted status by exactly one cycle;
- status changes only on a commit or a wake clear;
- a bus-error cycle leaves status untouched;
- a wake clear really drops the cleared bits;
- the countdown decrements by one without ever being reloaded;
- a write to the status select never disturbs the configuration.

Some behaviour shows only in the bench's scenarios against its cycle model:
- which sources qualify as a wake once masks and enables combine;
- that a strobe without the clock bit set is legal even with other bits clear;
- the exact 41,032-cycle distance from wake to resume;
- that a strobe coinciding with a wake is dropped.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;

    localparam int DOM_W = 10;

    localparam int D_CPU    = 0;
    localparam int D_MPORT  = 1;
    localparam int D_ICACHE = 2;
    localparam int D_PERIPH = 3;
    localparam int D_CLKGEN = 4;
    localparam int D_EXTMEM = 5;
    localparam int D_IOPORT = 6;
    localparam int D_DMAPRT = 7;
    localparam int D_IPORT  = 8;
    localparam int D_CLKEXT = 9;

    typedef logic [DOM_W-1:0] dom_vec_t;

    // Bits that must accompany the clock-generator bit for a legal stop.
    localparam dom_vec_t STOP_NEED = dom_vec_t'((1 << D_CPU) | (1 << D_MPORT) | (1 << D_ICACHE) |
                                                (1 << D_EXTMEM) | (1 << D_IOPORT) | (1 << D_DMAPRT) |
                                                (1 << D_IPORT) | (1 << D_CLKEXT));

    // Status bits dropped when the CPU is woken.
    localparam dom_vec_t WAKE_CLR = dom_vec_t'((1 << D_CPU) | (1 << D_CLKGEN) | (1 << D_EXTMEM) |
                                               (1 << D_IOPORT) | (1 << D_IPORT));

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_WAKE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic        wr;
        reg_sel_e    sel;
        logic [15:0] wdata;
    } bus_req_t;

    function automatic logic clk_stop_ok(input dom_vec_t c);
        return !c[D_CLKGEN] || ((c & STOP_NEED) == STOP_NEED);
    endfunction

    function automatic dom_vec_t apply_wake(input dom_vec_t s);
        return s & ~WAKE_CLR;
    endfunction

endpackage

// File: rtl/idle_cfg_regs.sv
module idle_cfg_regs
    import idle_ctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WE_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  dom_vec_t          status_i,
    output dom_vec_t          cfg_o,
    output logic [WE_W-1:0]   wake_en_o,
    output logic [DATA_W-1:0] rdata_o
);

    dom_vec_t        cfg_q;
    logic [WE_W-1:0] we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            we_q  <= '0;
        end else if (req.wr) begin
            if (req.sel == SEL_CFG)  cfg_q <= req.wdata[DOM_W-1:0];
            if (req.sel == SEL_WAKE) we_q  <= req.wdata[WE_W-1:0];
        end
    end

    always_comb begin
        case (req.sel)
            SEL_CFG:  rdata_o = DATA_W'(cfg_q);
            SEL_STAT: rdata_o = DATA_W'(status_i);
            SEL_WAKE: rdata_o = DATA_W'(we_q);
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o     = cfg_q;
    assign wake_en_o = we_q;

    // R3
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_STAT) |=> $stable(cfg_q));

endmodule

// File: rtl/idle_commit.sv
module idle_commit
    import idle_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_i,
    input  logic     hold_i,
    input  logic     wake_clr_i,
    input  dom_vec_t cfg_i,
    output dom_vec_t status_o,
    output logic     bus_err_o
);

    dom_vec_t status_q;
    logic     err_q;
    logic     take;

    assign take = strobe_i && !hold_i && !wake_clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (wake_clr_i) begin
                status_q <= apply_wake(status_q);
            end else if (take) begin
                if (clk_stop_ok(cfg_i)) status_q <= cfg_i;
                else                    err_q    <= 1'b1;
            end
        end
    end

    assign status_o  = status_q;
    assign bus_err_o = err_q;

    // R6
    err_keeps_status_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $stable(status_q));

    // R4
    status_only_on_event_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_i && !wake_clr_i) |=> $stable(status_q));

    // R8
    wake_drops_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        wake_clr_i |=> (!status_q[D_CPU] && !status_q[D_CLKGEN] && !status_q[D_IPORT]));

endmodule

// File: rtl/idle_wake.sv
module idle_wake
    import idle_ctl_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int STAB_CYCLES = 41032
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic             nmi_i,
    input  logic [N_IRQ:0]   wake_en_i,
    input  dom_vec_t         status_i,
    output logic             wake_clr_o,
    output logic             hold_o,
    output logic             resume_o
);

    localparam int CNT_W = $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STAB_CYCLES - 1);

    logic             wake_ev;
    logic             accept;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             resume_q;

    assign wake_ev = (nmi_i && wake_en_i[N_IRQ]) ||
                     (|(irq_i & irq_en_i & wake_en_i[N_IRQ-1:0]));
    assign accept  = !run_q && wake_ev && status_i[D_CPU];

    assign wake_clr_o = (run_q && cnt_q == '0) || (accept && !status_i[D_CLKGEN]);
    assign hold_o     = run_q || accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            cnt_q    <= '0;
            resume_q <= 1'b0;
        end else begin
            resume_q <= wake_clr_o;
            if (run_q) begin
                if (cnt_q == '0) run_q <= 1'b0;
                else             cnt_q <= cnt_q - 1'b1;
            end else if (accept && status_i[D_CLKGEN]) begin
                run_q <= 1'b1;
                cnt_q <= CNT_LOAD;
            end
        end
    end

    assign resume_o = resume_q;

    // R10
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != '0) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

    // R9
    cnt_start_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && status_i[D_CLKGEN]) |=> (run_q && cnt_q == CNT_LOAD && !resume_q));

    // R8
    resume_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wake_clr_o |=> resume_q);

endmodule

// File: rtl/idle_commit_ctrl.sv
module idle_commit_ctrl
    import idle_ctl_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int N_IRQ       = 4,
    parameter int STAB_CYCLES = 41032
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              idle_strobe,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic              nmi_in,
    output logic [DOM_W-1:0]  dom_clk_en,
    output logic              bus_err,
    output logic              cpu_resume
);

    localparam int WE_W = N_IRQ + 1;

    bus_req_t        req;
    dom_vec_t        cfg;
    dom_vec_t        status;
    logic [WE_W-1:0] wake_en;
    logic            wake_clr;
    logic            hold;

    assign req.wr    = bus_wr;
    assign req.sel   = reg_sel_e'(bus_sel);
    assign req.wdata = 16'(bus_wdata);

    idle_cfg_regs #(.DATA_W(DATA_W), .WE_W(WE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .status_i  (status),
        .cfg_o     (cfg),
        .wake_en_o (wake_en),
        .rdata_o   (bus_rdata)
    );

    idle_commit u_commit (
        .clk        (clk),
        .rst        (rst),
        .strobe_i   (idle_strobe),
        .hold_i     (hold),
        .wake_clr_i (wake_clr),
        .cfg_i      (cfg),
        .status_o   (status),
        .bus_err_o  (bus_err)
    );

    idle_wake #(.N_IRQ(N_IRQ), .STAB_CYCLES(STAB_CYCLES)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .irq_i      (irq_in),
        .irq_en_i   (irq_en),
        .nmi_i      (nmi_in),
        .wake_en_i  (wake_en),
        .status_i   (status),
        .wake_clr_o (wake_clr),
        .hold_o     (hold),
        .resume_o   (cpu_resume)
    );

    for (genvar d = 0; d < DOM_W; d++) begin : g_en
        logic en_q;
        always_ff @(posedge clk) begin
            if (rst) en_q <= 1'b1;
            else     en_q <= ~status[d];
        end
        assign dom_clk_en[d] = en_q;
    end

    // R5
    en_tracks_status_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dom_clk_en == ~$past(status)));

endmodule

// File: tb/idle_commit_ctrl_tb.sv
`timescale 1ns/1ps
module idle_commit_ctrl_tb;

    localparam int STAB    = 41032;
    localparam int WDOG    = 150000;
    localparam logic [9:0] NEED = 10'h3E7;
    localparam logic [9:0] CLRM = 10'h171;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        idle_strobe = 1'b0;
    logic [3:0]  irq_in = '0;
    logic [3:0]  irq_en = '0;
    logic        nmi_in = 1'b0;
    logic [9:0]  dom_clk_en;
    logic        bus_err;
    logic        cpu_resume;

    always #2.5 clk = ~clk;

    idle_commit_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_sel     (bus_sel),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .idle_strobe (idle_strobe),
        .irq_in      (irq_in),
        .irq_en      (irq_en),
        .nmi_in      (nmi_in),
        .dom_clk_en  (dom_clk_en),
        .bus_err     (bus_err),
        .cpu_resume  (cpu_resume)
    );

    // behavioural reference state
    logic [9:0] m_cfg, m_st, m_en;
    logic [4:0] m_we;
    bit         m_err, m_res;
    int         m_cnt = -1;
    int         vectors = 0;
    int         misses = 0;
    int         cycles = 0;
    string      cur_req = "R1";

    function automatic logic [15:0] m_read(input logic [1:0] s);
        case (s)
            2'd0:    return {6'b0, m_cfg};
            2'd1:    return {6'b0, m_st};
            2'd2:    return {11'b0, m_we};
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_step();
        logic [9:0] en_n;
        bit ev;
        en_n  = ~m_st;
        m_err = 0;
        m_res = 0;
        ev = (nmi_in && m_we[4]) || ((irq_in & irq_en & m_we[3:0]) != 0);
        if (m_cnt >= 0) begin
            if (m_cnt == 0) begin
                m_st  = m_st & ~CLRM;
                m_res = 1;
                m_cnt = -1;
            end else m_cnt--;
        end else if (ev && m_st[0]) begin
            if (m_st[4]) m_cnt = STAB - 1;
            else begin
                m_st  = m_st & ~CLRM;
                m_res = 1;
            end
        end else if (idle_strobe) begin
            if (m_cfg[4] && ((m_cfg & NEED) != NEED)) m_err = 1;
            else m_st = m_cfg;
        end
        if (bus_wr && bus_sel == 2'd0) m_cfg = bus_wdata[9:0];
        if (bus_wr && bus_sel == 2'd2) m_we  = bus_wdata[4:0];
        m_en = en_n;
    endtask

    task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %h expected %h at cycle %0d", cur_req, what, got, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cfg = '0; m_st = '0; m_we = '0; m_en = '1;
            m_err = 0; m_res = 0; m_cnt = -1;
        end else model_step();
        #1;
        check("dom_clk_en (R5)", {6'b0, dom_clk_en}, {6'b0, m_en});
        check("bus_err (R6)", {15'b0, bus_err}, {15'b0, m_err});
        check("cpu_resume (R8/R9)", {15'b0, cpu_resume}, {15'b0, m_res});
        check("bus_rdata", bus_rdata, m_read(bus_sel));
    end

    always @(posedge clk) begin
        if (cycles > WDOG) begin
            misses++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        idle_strobe = 1'b1;
        @(negedge clk);
        idle_strobe = 1'b0;
    endtask

    task automatic show(input logic [1:0] s);
        @(negedge clk);
        bus_sel = s;
        tick(2);
    endtask

    initial begin
        // R1: reset state on all three registers
        tick(3);
        rst = 1'b0;
        show(2'd0); show(2'd1); show(2'd2);

        // R2: configuration write, reserved bits read zero
        cur_req = "R2";
        wr(2'd0, 16'hFFFF);
        show(2'd0);
        // R3: staged write leaves status alone; status write ignored
        cur_req = "R3";
        show(2'd1);
        wr(2'd1, 16'h0155);
        show(2'd1); show(2'd0);

        // R4: legal commit without clock stop
        cur_req = "R4";
        wr(2'd0, 16'h000A);
        strobe();
        show(2'd1);
        tick(3);

        // R6: illegal clock stop variants
        cur_req = "R6";
        wr(2'd0, 16'h0010);
        strobe(); show(2'd1);
        wr(2'd0, 16'h01F7);
        strobe(); show(2'd1);
        // peripheral bit not needed for a legal stop, but CPU bit absent here
        wr(2'd0, 16'h03F6);
        strobe(); show(2'd1);

        // R7: wake-enable register and source qualification
        cur_req = "R7";
        wr(2'd2, 16'hFFEF);
        show(2'd2);
        irq_in = 4'hF; irq_en = 4'h0;
        tick(4);
        irq_in = 4'h0;
        cur_req = "R8";
        wr(2'd0, 16'h0163);
        strobe();
        show(2'd1);
        cur_req = "R7";
        irq_in = 4'b0100; irq_en = 4'b1011;
        tick(4);
        nmi_in = 1'b1;
        tick(4);
        nmi_in = 1'b0;
        show(2'd1);
        // R8: enabled source wakes, partial clear
        cur_req = "R8";
        @(negedge clk);
        irq_en = 4'b0100;
        tick(2);
        irq_in = 4'h0;
        show(2'd1); show(2'd0);

        // R11: wake and strobe in the same cycle
        cur_req = "R11";
        strobe();
        show(2'd1);
        wr(2'd0, 16'h0021);
        @(negedge clk);
        irq_in = 4'b0100; idle_strobe = 1'b1;
        @(negedge clk);
        irq_in = 4'h0; idle_strobe = 1'b0;
        show(2'd1);

        // R9: full clock stop, wake by NMI, long countdown
        cur_req = "R9";
        wr(2'd2, 16'h0010);
        wr(2'd0, 16'h03F7);
        strobe();
        show(2'd1);
        @(negedge clk);
        nmi_in = 1'b1;
        @(negedge clk);
        nmi_in = 1'b0;
        // R10: further interrupts and strobes during countdown
        cur_req = "R10";
        tick(100);
        nmi_in = 1'b1;
        wr(2'd0, 16'h0000);
        strobe();
        nmi_in = 1'b0;
        tick(STAB - 120);
        cur_req = "R9";
        show(2'd1);
        tick(20);
        show(2'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule